// File: doc/BRIEF.md
# Flash Byte Program Sequencer

This controller writes a run of bytes into an external electrically programmable flash array. It reaches the array only through a simple bus master port, where each bus cycle is a request held until the device acknowledges it. For every byte it carries out a program-and-check loop. It sends the program set-up command, then the address and data write, which opens a timed high-voltage pulse. After the pulse it sends the verify command and waits for the margin read to settle. It then reads the byte back and compares the result with the intended value. While the job is running, the sequencer holds an enable that switches on the external programming supply.

The block has two data sources. In stream mode the bytes come from a valid/ready source. In fill mode every byte is written as 00h and the source is never consumed; an erase controller uses this mode to pre-program a region before erasing it. The pulse length, the settle delay and the number of tries allowed per byte are parameters counted in clock cycles. When a job ends, a one-cycle completion strobe is raised. If a byte was rejected, a fail flag, the failing address and the last value read back are also given.

Top module: `flash_byte_prog`

## Requirements
- R1: While reset is held and after it is released, bus_req_o, hv_en_o, done_o, fail_o and src_ready_o are all 0.
- R2: A start with a non-zero count raises hv_en_o in the next cycle. Each try is four bus cycles in this order: a write of 40h, a write of the byte to its address, exactly PULSE_CYC idle cycles, a write of C0h, exactly VFY_CYC idle cycles, and then a read of the byte's address. hv_en_o is 1 through all four cycles.
- R3: When the read-back value equals the byte, the next byte is handled at the address plus one. The try count starts again at zero for each byte.
- R4: On a mismatch the try is repeated, starting from the 40h write. A byte may receive at most PULSE_LIMIT tries, and a match on the last allowed try counts as a pass.
- R5: Once the last byte has passed, hv_en_o falls, one write of 00h is made with hv_en_o at 0, and done_o is then high for exactly one cycle with fail_o at 0.
- R6: If a byte still mismatches after PULSE_LIMIT tries, hv_en_o falls and no further bus cycle is made. done_o is raised together with fail_o=1, fail_addr_o set to the byte's address and fail_data_o set to the value read back. fail_o and its fields hold until the next accepted start.
- R7: In stream mode (fill_zero_i=0) exactly one source byte is taken per address, through src_valid_i/src_ready_o. src_ready_o is high only while the block waits for a byte and no bus cycle is open.
- R8: In fill mode (fill_zero_i=1) every byte is written and compared as 00h, and src_ready_o stays 0 for the whole job.
- R9: A start with a count of zero raises done_o in the next cycle, with fail_o at 0. No bus cycle is made and hv_en_o stays 0.
- R10: start_i is ignored while a job is running, and the base address, count and mode inputs are used only in the start cycle.
- R11: bus_req_o stays high with bus_we_o, bus_addr_o and bus_wdata_o stable until the cycle in which bus_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled only while idle |
| base_addr_i | input | AW | First byte address of the job |
| byte_count_i | input | CW | Number of bytes in the job |
| fill_zero_i | input | 1 | 1: write 00h everywhere, 0: take bytes from the source |
| src_data_i | input | 8 | Source byte |
| src_valid_i | input | 1 | Source byte available |
| src_ready_o | output | 1 | Source byte taken in this cycle when valid |
| bus_req_o | output | 1 | Bus cycle request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_ack_i | input | 1 | Bus cycle completion |
| bus_rdata_i | input | 8 | Read data, valid with bus_ack_i |
| hv_en_o | output | 1 | Programming supply enable |
| done_o | output | 1 | One-cycle job completion strobe |
| fail_o | output | 1 | Last job stopped on a rejected byte |
| fail_addr_o | output | AW | Address of the rejected byte |
| fail_data_o | output | 8 | Last value read from the rejected byte |

## Verification
The corner that needs the most care is the verify read that happens on the final allowed try. In that one acknowledged cycle, the compare result and the try-limit test are decided together, and they point to opposite outcomes. The bench sets up the flash model so that one byte accepts on exactly its PULSE_LIMIT-th pulse, and another needs one pulse more. The first case must close with the 00h write and a clean completion. The second must stop without any further bus cycle and report the address and read-back value. A second overlap is also exercised: a start request made in the middle of a job has to be ignored, with no change to the bus sequence.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_LOAD,
    ST_PULSE,
    ST_ARM,
    ST_SETTLE,
    ST_CHECK,
    ST_RDCMD,
    ST_END
  } fps_state_e;

  localparam logic [7:0] CMD_PGM_SETUP  = 8'h40;
  localparam logic [7:0] CMD_PGM_VERIFY = 8'hC0;
  localparam logic [7:0] CMD_READ_ARRAY = 8'h00;
  localparam logic [7:0] FILL_VALUE     = 8'h00;

endpackage

// File: rtl/fps_delay.sv
module fps_delay #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] val_i,
  output logic          expired_o
);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : (cnt_q - DW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/fps_cursor.sv
module fps_cursor #(
  parameter int AW = 17,
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] left_q, left_d;
  logic          upd_en;

  always_comb begin
    upd_en = load_i || step_i;
    if (load_i) begin
      addr_d = base_i;
      left_d = count_i - CW'(1);
    end else begin
      addr_d = addr_q + AW'(1);
      left_d = left_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (left_q == '0);

endmodule

// File: rtl/fps_retry.sv
module fps_retry #(
  parameter int LIMIT = 25,
  parameter int PW    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic bump_i,
  output logic final_o
);

  logic [PW-1:0] tries_q, tries_d;
  logic          tries_en;

  always_comb begin
    tries_en = clear_i || bump_i;
    tries_d  = clear_i ? '0 : (tries_q + PW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tries_q <= '0;
    else if (tries_en) tries_q <= tries_d;
  end

  assign final_o = (tries_q == PW'(LIMIT - 1));

endmodule

// File: rtl/flash_byte_prog.sv
module flash_byte_prog #(
  parameter int AW          = 17,
  parameter int CW          = 17,
  parameter int PULSE_CYC   = 200,
  parameter int VFY_CYC     = 120,
  parameter int PULSE_LIMIT = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] byte_count_i,
  input  logic          fill_zero_i,
  input  logic [7:0]    src_data_i,
  input  logic          src_valid_i,
  output logic          src_ready_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [7:0]    bus_rdata_i,
  output logic          hv_en_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [7:0]    fail_data_o
);
  import fps_pkg::*;

  localparam int LONGEST = (PULSE_CYC > VFY_CYC) ? PULSE_CYC : VFY_CYC;
  localparam int DW      = $clog2(LONGEST + 1);
  localparam int PW      = $clog2(PULSE_LIMIT + 1);

  // reset: asserted at once, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  fps_state_e    state_q, state_d;
  logic [AW-1:0] cur_addr;
  logic          cur_last;
  logic          try_final;
  logic          wait_over;

  logic          accept, zero_go, take, chk_done, match;
  logic          pass_last, pass_next, give_up, retry;
  logic          tmr_load;
  logic [DW-1:0] tmr_val;

  logic          fill_q;
  logic [7:0]    data_q, data_d;
  logic          hv_q, hv_en;
  logic          fail_q, fail_en;
  logic [AW-1:0] faddr_q;
  logic [7:0]    fdata_q;

  // event decode
  always_comb begin
    accept    = (state_q == ST_IDLE) && start_i && (byte_count_i != '0);
    zero_go   = (state_q == ST_IDLE) && start_i && (byte_count_i == '0);
    take      = (state_q == ST_FETCH) && (fill_q || src_valid_i);
    chk_done  = (state_q == ST_CHECK) && bus_ack_i;
    match     = (bus_rdata_i == data_q);
    pass_last = chk_done && match && cur_last;
    pass_next = chk_done && match && !cur_last;
    give_up   = chk_done && !match && try_final;
    retry     = chk_done && !match && !try_final;
    tmr_load  = bus_ack_i && ((state_q == ST_LOAD) || (state_q == ST_ARM));
    tmr_val   = (state_q == ST_LOAD) ? DW'(PULSE_CYC - 1) : DW'(VFY_CYC - 1);
    data_d    = fill_q ? FILL_VALUE : src_data_i;
    hv_en     = accept || pass_last || give_up;
    fail_en   = accept || zero_go || give_up;
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (zero_go) state_d = ST_END;
                 else if (accept) state_d = ST_FETCH;
      ST_FETCH:  if (take) state_d = ST_SETUP;
      ST_SETUP:  if (bus_ack_i) state_d = ST_LOAD;
      ST_LOAD:   if (bus_ack_i) state_d = ST_PULSE;
      ST_PULSE:  if (wait_over) state_d = ST_ARM;
      ST_ARM:    if (bus_ack_i) state_d = ST_SETTLE;
      ST_SETTLE: if (wait_over) state_d = ST_CHECK;
      ST_CHECK: begin
        if (pass_last)      state_d = ST_RDCMD;
        else if (pass_next) state_d = ST_FETCH;
        else if (give_up)   state_d = ST_END;
        else if (retry)     state_d = ST_SETUP;
      end
      ST_RDCMD:  if (bus_ack_i) state_d = ST_END;
      ST_END:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  // job registers with explicit enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fill_q <= 1'b0;
      data_q <= '0;
      hv_q   <= 1'b0;
    end else begin
      if (accept) fill_q <= fill_zero_i;
      if (take)   data_q <= data_d;
      if (hv_en)  hv_q   <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
      fdata_q <= '0;
    end else if (fail_en) begin
      fail_q  <= give_up;
      faddr_q <= give_up ? cur_addr : '0;
      fdata_q <= give_up ? bus_rdata_i : '0;
    end
  end

  fps_cursor #(.AW(AW), .CW(CW)) u_cursor (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (accept),
    .base_i  (base_addr_i),
    .count_i (byte_count_i),
    .step_i  (pass_next),
    .addr_o  (cur_addr),
    .last_o  (cur_last)
  );

  fps_retry #(.LIMIT(PULSE_LIMIT), .PW(PW)) u_retry (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear_i (take),
    .bump_i  (retry),
    .final_o (try_final)
  );

  fps_delay #(.DW(DW)) u_delay (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (wait_over)
  );

  // bus and status outputs, decoded from registered state
  always_comb begin
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b1;
    bus_wdata_o = CMD_READ_ARRAY;
    unique case (state_q)
      ST_SETUP: begin bus_req_o = 1'b1; bus_wdata_o = CMD_PGM_SETUP;  end
      ST_LOAD:  begin bus_req_o = 1'b1; bus_wdata_o = data_q;         end
      ST_ARM:   begin bus_req_o = 1'b1; bus_wdata_o = CMD_PGM_VERIFY; end
      ST_CHECK: begin bus_req_o = 1'b1; bus_we_o    = 1'b0;           end
      ST_RDCMD: begin bus_req_o = 1'b1; bus_wdata_o = CMD_READ_ARRAY; end
      default:  ;
    endcase
  end

  assign bus_addr_o  = cur_addr;
  assign src_ready_o = (state_q == ST_FETCH) && !fill_q;
  assign hv_en_o     = hv_q;
  assign done_o      = (state_q == ST_END);
  assign fail_o      = fail_q;
  assign fail_addr_o = faddr_q;
  assign fail_data_o = fdata_q;

endmodule

// File: rtl/fps_checks.sv
module fps_checks #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          src_ready_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [7:0]    bus_wdata_o,
  input logic          bus_ack_i,
  input logic          hv_en_o,
  input logic          done_o,
  input logic          fail_o
);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o) &&
      $stable(bus_addr_o) && $stable(bus_wdata_o));

  assert_cmd_under_hv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && bus_we_o && (bus_wdata_o == 8'h40 || bus_wdata_o == 8'hC0) |-> hv_en_o);

  assert_read_under_hv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_we_o |-> hv_en_o);

  assert_low_hv_readcmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !hv_en_o |-> bus_we_o && bus_wdata_o == 8'h00);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_fail_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> done_o && !hv_en_o);

  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready_o |-> !bus_req_o && hv_en_o);

endmodule

bind flash_byte_prog fps_checks #(.AW(AW)) u_fps_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_ready_o (src_ready_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i),
  .hv_en_o     (hv_en_o),
  .done_o      (done_o),
  .fail_o      (fail_o)
);

// File: tb/flash_byte_prog_test.sv
module flash_byte_prog_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 17;
  localparam int CW    = 17;
  localparam int PULSE = 7;
  localparam int VFY   = 4;
  localparam int LIMIT = 25;

  logic          clk, rst_n, start_i, fill_zero_i, src_valid_i, src_ready_o;
  logic [AW-1:0] base_addr_i, bus_addr_o, fail_addr_o;
  logic [CW-1:0] byte_count_i;
  logic [7:0]    src_data_i, bus_wdata_o, bus_rdata_i, fail_data_o;
  logic          bus_req_o, bus_we_o, bus_ack_i, hv_en_o, done_o, fail_o;

  flash_byte_prog #(.AW(AW), .CW(CW), .PULSE_CYC(PULSE), .VFY_CYC(VFY),
                    .PULSE_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .byte_count_i(byte_count_i), .fill_zero_i(fill_zero_i),
    .src_data_i(src_data_i), .src_valid_i(src_valid_i), .src_ready_o(src_ready_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
    .hv_en_o(hv_en_o), .done_o(done_o), .fail_o(fail_o),
    .fail_addr_o(fail_addr_o), .fail_data_o(fail_data_o));

  typedef struct {
    logic          we;
    logic          chk_addr;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    logic          hv;
  } txn_t;

  txn_t       expq[$];
  logic [7:0] src_q[$];
  logic [7:0] job_data[$];
  int         job_need[$];
  logic [7:0] store[int];
  int         pulses[int];
  int         need[int];
  int         vectors = 0;
  int         misses  = 0;
  int         src_gap = 0;
  bit         fill_run = 0;
  bit         saw_ready = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic void push(logic we, logic ca, logic [AW-1:0] a, logic [7:0] d, logic hv);
    txn_t t;
    t.we = we; t.chk_addr = ca; t.addr = a; t.data = d; t.hv = hv;
    expq.push_back(t);
  endfunction

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // flash device model and bus transaction comparison
  initial begin
    int   wait_cnt, lat, gap_kind, gap_cnt, ntx, a;
    bit   after_setup;
    txn_t e;
    wait_cnt = 0; lat = 1; gap_kind = 0; gap_cnt = 0; ntx = 0; after_setup = 0;
    bus_ack_i = 1'b0; bus_rdata_i = 8'h00;
    forever begin
      @(negedge clk);
      if (gap_kind != 0) begin
        if (!bus_req_o) gap_cnt++;
        else begin
          if (gap_kind == 1) chk("R2 pulse length", gap_cnt, PULSE);
          else               chk("R2 verify settle", gap_cnt, VFY);
          gap_kind = 0;
        end
      end
      if (bus_ack_i) bus_ack_i = 1'b0;
      else if (bus_req_o) begin
        if (wait_cnt >= lat) begin
          a = int'(bus_addr_o);
          if (expq.size() == 0) begin
            chk("R10 unexpected bus cycle", {bus_we_o, 7'd0, bus_wdata_o}, 32'hFFFF);
          end else begin
            e = expq.pop_front();
            chk("R2 bus direction", bus_we_o, e.we);
            chk("R2 supply enable during cycle", hv_en_o, e.hv);
            if (e.we)       chk("R2 write data", bus_wdata_o, e.data);
            if (e.chk_addr) chk("R3 bus address", bus_addr_o, e.addr);
          end
          if (bus_we_o) begin
            if (after_setup) begin
              store[a] = bus_wdata_o;
              pulses[a] = pulses.exists(a) ? pulses[a] + 1 : 1;
              gap_kind = 1; gap_cnt = 0; after_setup = 0;
            end else begin
              after_setup = (bus_wdata_o == 8'h40);
              if (bus_wdata_o == 8'hC0) begin gap_kind = 2; gap_cnt = 0; end
            end
          end else begin
            if (pulses.exists(a) && pulses[a] >= (need.exists(a) ? need[a] : 1))
              bus_rdata_i = store[a];
            else
              bus_rdata_i = (store.exists(a) ? store[a] : 8'hFF) ^ 8'h10;
          end
          bus_ack_i = 1'b1;
          wait_cnt = 0;
          ntx++;
          lat = 1 + (ntx % 3);
        end else wait_cnt++;
      end
    end
  end

  // byte source with gaps; garbage valid during fill runs
  initial begin
    bit fire;
    int hold;
    fire = 0; hold = 0;
    src_valid_i = 1'b0; src_data_i = 8'h00;
    forever begin
      @(negedge clk);
      if (fire && src_q.size() > 0) begin
        void'(src_q.pop_front());
        src_valid_i = 1'b0;
        hold = src_gap;
      end
      fire = 0;
      if (fill_run) begin
        src_valid_i = 1'b1; src_data_i = 8'h5A;
        if (src_ready_o) saw_ready = 1;
      end else if (!src_valid_i && src_q.size() > 0) begin
        if (hold > 0) hold--;
        else begin src_valid_i = 1'b1; src_data_i = src_q[0]; end
      end else if (src_q.size() == 0) src_valid_i = 1'b0;
      fire = src_valid_i && src_ready_o && !fill_run;
    end
  end

  task automatic run_job(input logic [AW-1:0] base, input int n, input bit fill,
                         input int gap, input bit poke, input string name);
    int fail_at, k, cnt;
    logic [7:0] d;
    store.delete(); pulses.delete(); need.delete(); expq.delete();
    fail_at = -1;
    for (int i = 0; i < n; i++) begin
      d = fill ? 8'h00 : job_data[i];
      need[int'(base + AW'(i))] = job_need[i];
      k = (job_need[i] > LIMIT) ? LIMIT : job_need[i];
      for (int p = 0; p < k; p++) begin
        push(1, 0, '0, 8'h40, 1);
        push(1, 1, base + AW'(i), d, 1);
        push(1, 0, '0, 8'hC0, 1);
        push(0, 1, base + AW'(i), 8'h00, 1);
      end
      if (job_need[i] > LIMIT) begin fail_at = i; break; end
    end
    if (fail_at < 0 && n > 0) push(1, 0, '0, 8'h00, 0);
    src_q.delete();
    if (!fill) for (int i = 0; i < n; i++) src_q.push_back(job_data[i]);
    src_gap = gap; fill_run = fill; saw_ready = 0;

    @(negedge clk);
    start_i = 1'b1; base_addr_i = base; byte_count_i = CW'(n); fill_zero_i = fill;
    @(negedge clk);
    start_i = 1'b0; base_addr_i = ~base; byte_count_i = CW'(n + 5); fill_zero_i = ~fill;
    if (n == 0) begin
      chk({name, " R9 done next cycle"}, done_o, 1);
      chk({name, " R9 supply stays off"}, hv_en_o, 0);
    end else chk({name, " R2 supply enable rises"}, hv_en_o, 1);
    cnt = 0;
    while (!done_o && cnt < 20000) begin
      @(negedge clk);
      cnt++;
      start_i = (poke && cnt == 40);
      if (start_i) begin base_addr_i = '0; byte_count_i = CW'(3); end
      if (n == 0) chk({name, " R9 no bus cycle"}, bus_req_o, 0);
    end
    start_i = 1'b0;
    chk({name, " R5 completion seen"}, done_o, 1);
    chk({name, " R6 fail flag"}, fail_o, (fail_at >= 0));
    chk({name, " R5 supply off at end"}, hv_en_o, 0);
    chk({name, " R4 all expected bus cycles made"}, expq.size(), 0);
    if (fail_at >= 0) begin
      chk({name, " R6 fail address"}, fail_addr_o, base + AW'(fail_at));
      chk({name, " R6 fail data"}, fail_data_o,
          (fill ? 8'h00 : job_data[fail_at]) ^ 8'h10);
    end
    if (!fill) chk({name, " R7 source bytes consumed"}, src_q.size(),
                   (fail_at >= 0) ? (n - fail_at - 1) : 0);
    else chk({name, " R8 source never ready"}, saw_ready, 0);
    fill_run = 0;
    src_q.delete();
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk({name, " R6 quiet after completion"}, bus_req_o, 0);
      chk({name, " R6 fail flag held"}, fail_o, (fail_at >= 0));
      chk({name, " R5 strobe one cycle"}, done_o, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; base_addr_i = '0; byte_count_i = '0; fill_zero_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset bus_req", bus_req_o, 0);
    chk("R1 reset hv_en", hv_en_o, 0);
    chk("R1 reset done", done_o, 0);
    chk("R1 reset fail", fail_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle src_ready", src_ready_o, 0);
    chk("R1 idle bus_req", bus_req_o, 0);

    // stream job, per-byte retry counts that only fit if the count restarts (R3)
    job_data = '{8'hA5, 8'h40, 8'hC0, 8'h3C};
    job_need = '{20, 1, 22, 3};
    run_job(17'h00100, 4, 0, 2, 1, "stream+R10");

    // fill mode at the top of the address space
    job_data = '{8'h00, 8'h00};
    job_need = '{2, 1};
    run_job(17'h1FFFE, 2, 1, 0, 0, "fill R8");

    // pass exactly on the last allowed try
    job_data = '{8'h5E};
    job_need = '{LIMIT};
    run_job(17'h0ABCD, 1, 0, 0, 0, "limit-pass R4");

    // second byte never takes
    job_data = '{8'h11, 8'h22, 8'h33};
    job_need = '{1, LIMIT + 1, 1};
    run_job(17'h00200, 3, 0, 1, 0, "limit-fail R6");

    // zero count clears the fail report
    job_data.delete(); job_need.delete();
    run_job(17'h00300, 0, 0, 0, 0, "zero R9");

    job_data = '{8'h00};
    job_need = '{1};
    run_job(17'h00050, 1, 1, 0, 0, "fill-after R5");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule